// File: doc/BRIEF.md
# Variable-Length Vector Beat Sequencer

This block drives a four-lane, 32-bit-per-lane vector datapath whose register storage is an external file of 128-bit slices. Software sets the active vector length through a configuration write. Every vector instruction then runs over length/4 beats. On each beat the sequencer addresses the next slice of each source and of the destination. It computes the four lane results, merges them with the destination's old contents under a per-element mask, and drives one slice write.

A logical vector register `v` maps to the physical slices `v*n` through `v*n+n-1`, where `n` is the beat count. The length and the mask are latched when an instruction is accepted, so writes to them during execution only affect later instructions. An instruction that would reach past the last slice is refused, and the refusal is reported. A length write with an illegal value is dropped and sets a sticky error flag.

Top module: `vseq_top`

## Requirements
- R1: After reset `busy`, `done`, `wr_en`, `range_err` and `len_err` are 0, the length is 4 words (one beat per instruction), and every mask bit is 1.
- R2: A write with `cfg_sel`=0 and a value that is a multiple of 4 in the range 4..32 sets the length, and later instructions take length/4 beats.
- R3: A length write with any other value (0, not a multiple of 4, or above 32) keeps the previous length and sets `len_err`, which stays 1 until reset.
- R4: `issue_valid` is taken only while `busy` is 0. An issue presented while busy has no effect on the register file or on the beat count.
- R5: On beat k (counted from 0) the block reads slice `va*n+k` on port a, `vb*n+k` on port b and `vd*n+k` on port d, and it writes slice `vd*n+k`. The read ports are combinational.
- R6: The opcode `issue_op` selects the per-lane operation: 0 = a+b, 1 = a-b, 2 = low 32 bits of a*b, 3 = copy of a. Lane i occupies bits [32i+31:32i] of a slice.
- R7: Element e = 4k+i (beat k, lane i) receives the result when bit e of the mask is 1. When that bit is 0, the element is written back with its old destination value. A write with `cfg_sel`=1 loads all 32 mask bits.
- R8: `busy` is 1 from the cycle after acceptance for exactly n cycles, with one slice write in each of those cycles. `done` is 1 only in the last of them.
- R9: If `(v+1)*n > 32` for any of `vd`, `va`, `vb`, the issue is refused: `range_err` pulses for one cycle, `busy` stays 0 and nothing is written.
- R10: Length and mask writes made while an instruction runs do not change that instruction. They take effect from the next accepted instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Instruction present |
| issue_op | input | 2 | Lane operation code |
| issue_vd | input | 5 | Destination logical register |
| issue_va | input | 5 | First source logical register |
| issue_vb | input | 5 | Second source logical register |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 = length, 1 = mask |
| cfg_wdata | input | 32 | Configuration write value |
| rd_a_idx | output | 5 | Slice index, read port a |
| rd_a_data | input | 128 | Slice data, read port a |
| rd_b_idx | output | 5 | Slice index, read port b |
| rd_b_data | input | 128 | Slice data, read port b |
| rd_d_idx | output | 5 | Slice index, old destination read |
| rd_d_data | input | 128 | Old destination slice data |
| wr_en | output | 1 | Slice write enable |
| wr_idx | output | 5 | Slice write index |
| wr_data | output | 128 | Slice write data |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Final beat of the instruction |
| range_err | output | 1 | One-cycle pulse on a refused issue |
| len_err | output | 1 | Sticky illegal-length flag |

## Verification
Several properties are checked on every cycle. The stored length must always be a legal value, and `len_err` never clears once set. Busy can only start from an idle issue and ends right after `done`. The write index steps by one slice between beats, and a refusal never coincides with activity. The bench scenarios cover what needs a model of the register file: lane arithmetic, masked merge of old values, slice addressing at several lengths, the exact beat count, refused issues at the slice boundary, and configuration writes landing in the middle of an instruction.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
    typedef enum logic [1:0] {
        OP_ADD  = 2'd0,
        OP_SUB  = 2'd1,
        OP_MUL  = 2'd2,
        OP_COPY = 2'd3
    } vop_e;
endpackage

// File: rtl/vseq_cfg.sv
module vseq_cfg #(
    parameter int WORD_W  = 32,
    parameter int LANES   = 4,
    parameter int MAX_LEN = 32,
    parameter int LEN_W   = $clog2(MAX_LEN + 1),
    parameter int BEAT_W  = $clog2(MAX_LEN / LANES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic               cfg_sel,
    input  logic [WORD_W-1:0]  cfg_wdata,
    output logic [BEAT_W-1:0]  nbeats,
    output logic [MAX_LEN-1:0] mask,
    output logic               len_err
);
    typedef struct packed {
        logic [LEN_W-1:0]   len;
        logic [MAX_LEN-1:0] mask;
        logic               err;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic len_ok;

    always_comb begin
        len_ok = (cfg_wdata % LANES == 0) && (cfg_wdata != '0) && (cfg_wdata <= MAX_LEN);
        cfg_d  = cfg_q;
        if (cfg_we) begin
            if (cfg_sel) begin
                cfg_d.mask = cfg_wdata[MAX_LEN-1:0];
            end else if (len_ok) begin
                cfg_d.len = LEN_W'(cfg_wdata);
            end else begin
                cfg_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.len  <= LEN_W'(LANES);
            cfg_q.mask <= '1;
            cfg_q.err  <= 1'b0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign nbeats  = BEAT_W'(cfg_q.len / LANES);
    assign mask    = cfg_q.mask;
    assign len_err = cfg_q.err;

    a_r2_len_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.len % LANES == 0) && (cfg_q.len != '0) && (cfg_q.len <= MAX_LEN));
    a_r3_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.err |=> cfg_q.err);
endmodule

// File: rtl/vseq_lane.sv
module vseq_lane
    import vseq_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  vop_e              op,
    input  logic              en,
    input  logic [WORD_W-1:0] a,
    input  logic [WORD_W-1:0] b,
    input  logic [WORD_W-1:0] old,
    output logic [WORD_W-1:0] res
);
    logic [WORD_W-1:0] calc;

    always_comb begin
        unique case (op)
            OP_ADD:  calc = a + b;
            OP_SUB:  calc = a - b;
            OP_MUL:  calc = a * b;
            default: calc = a;
        endcase
        res = en ? calc : old;
    end
endmodule

// File: rtl/vseq_ctrl.sv
module vseq_ctrl
    import vseq_pkg::*;
#(
    parameter int LANES   = 4,
    parameter int SLICES  = 32,
    parameter int MAX_LEN = 32,
    parameter int SLICE_W = $clog2(SLICES),
    parameter int BEAT_W  = $clog2(MAX_LEN / LANES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               issue_valid,
    input  vop_e               issue_op,
    input  logic [SLICE_W-1:0] issue_vd,
    input  logic [SLICE_W-1:0] issue_va,
    input  logic [SLICE_W-1:0] issue_vb,
    input  logic [BEAT_W-1:0]  nbeats,
    input  logic [MAX_LEN-1:0] mask,
    output vop_e               cur_op,
    output logic [LANES-1:0]   lane_en,
    output logic [SLICE_W-1:0] rd_a_idx,
    output logic [SLICE_W-1:0] rd_b_idx,
    output logic [SLICE_W-1:0] rd_d_idx,
    output logic               wr_en,
    output logic [SLICE_W-1:0] wr_idx,
    output logic               busy,
    output logic               done,
    output logic               range_err
);
    localparam int PW = SLICE_W + BEAT_W + 1;

    typedef struct packed {
        logic               busy;
        logic               rerr;
        logic [BEAT_W-1:0]  beat;
        logic [BEAT_W-1:0]  nb;
        vop_e               op;
        logic [SLICE_W-1:0] bd;
        logic [SLICE_W-1:0] ba;
        logic [SLICE_W-1:0] bb;
        logic [MAX_LEN-1:0] mask;
    } seq_t;

    seq_t st_d, st_q;
    logic last_beat;

    function automatic logic fits(input logic [SLICE_W-1:0] v, input logic [BEAT_W-1:0] n);
        return ((PW'(v) + PW'(1)) * PW'(n)) <= PW'(SLICES);
    endfunction

    assign last_beat = (st_q.beat == st_q.nb - 1'b1);

    always_comb begin
        st_d      = st_q;
        st_d.rerr = 1'b0;
        if (st_q.busy) begin
            if (last_beat) begin
                st_d.busy = 1'b0;
                st_d.beat = '0;
            end else begin
                st_d.beat = st_q.beat + 1'b1;
            end
        end else if (issue_valid) begin
            if (fits(issue_vd, nbeats) && fits(issue_va, nbeats) && fits(issue_vb, nbeats)) begin
                st_d.busy = 1'b1;
                st_d.beat = '0;
                st_d.nb   = nbeats;
                st_d.op   = issue_op;
                st_d.bd   = SLICE_W'(PW'(issue_vd) * PW'(nbeats));
                st_d.ba   = SLICE_W'(PW'(issue_va) * PW'(nbeats));
                st_d.bb   = SLICE_W'(PW'(issue_vb) * PW'(nbeats));
                st_d.mask = mask;
            end else begin
                st_d.rerr = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.op   <= OP_ADD;
            st_q.nb   <= BEAT_W'(1);
            st_q.mask <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cur_op    = st_q.op;
    assign lane_en   = LANES'(st_q.mask >> (st_q.beat * LANES));
    assign rd_a_idx  = st_q.ba + SLICE_W'(st_q.beat);
    assign rd_b_idx  = st_q.bb + SLICE_W'(st_q.beat);
    assign rd_d_idx  = st_q.bd + SLICE_W'(st_q.beat);
    assign wr_idx    = st_q.bd + SLICE_W'(st_q.beat);
    assign wr_en     = st_q.busy;
    assign busy      = st_q.busy;
    assign done      = st_q.busy && last_beat;
    assign range_err = st_q.rerr;

    a_r4_start_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(issue_valid));
    a_r8_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    a_r8_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
    a_r5_slice_step: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> (wr_idx == SLICE_W'($past(wr_idx) + 1'b1)));
    a_r9_refuse_idle: assert property (@(posedge clk) disable iff (!rst_n)
        range_err |-> (!busy && !wr_en));
endmodule

// File: rtl/vseq_top.sv
module vseq_top
    import vseq_pkg::*;
#(
    parameter int WORD_W  = 32,
    parameter int LANES   = 4,
    parameter int SLICES  = 32,
    parameter int MAX_LEN = 32,
    parameter int SLICE_W = $clog2(SLICES),
    parameter int ROW_W   = WORD_W * LANES
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               issue_valid,
    input  logic [1:0]         issue_op,
    input  logic [SLICE_W-1:0] issue_vd,
    input  logic [SLICE_W-1:0] issue_va,
    input  logic [SLICE_W-1:0] issue_vb,
    input  logic               cfg_we,
    input  logic               cfg_sel,
    input  logic [WORD_W-1:0]  cfg_wdata,
    output logic [SLICE_W-1:0] rd_a_idx,
    input  logic [ROW_W-1:0]   rd_a_data,
    output logic [SLICE_W-1:0] rd_b_idx,
    input  logic [ROW_W-1:0]   rd_b_data,
    output logic [SLICE_W-1:0] rd_d_idx,
    input  logic [ROW_W-1:0]   rd_d_data,
    output logic               wr_en,
    output logic [SLICE_W-1:0] wr_idx,
    output logic [ROW_W-1:0]   wr_data,
    output logic               busy,
    output logic               done,
    output logic               range_err,
    output logic               len_err
);
    localparam int BEAT_W = $clog2(MAX_LEN / LANES + 1);

    logic [BEAT_W-1:0]  nbeats;
    logic [MAX_LEN-1:0] mask;
    logic [LANES-1:0]   lane_en;
    vop_e               cur_op;

    vseq_cfg #(.WORD_W(WORD_W), .LANES(LANES), .MAX_LEN(MAX_LEN)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .nbeats(nbeats), .mask(mask), .len_err(len_err)
    );

    vseq_ctrl #(.LANES(LANES), .SLICES(SLICES), .MAX_LEN(MAX_LEN)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid),
        .issue_op(vop_e'(issue_op)), .issue_vd(issue_vd), .issue_va(issue_va),
        .issue_vb(issue_vb), .nbeats(nbeats), .mask(mask), .cur_op(cur_op),
        .lane_en(lane_en), .rd_a_idx(rd_a_idx), .rd_b_idx(rd_b_idx),
        .rd_d_idx(rd_d_idx), .wr_en(wr_en), .wr_idx(wr_idx), .busy(busy),
        .done(done), .range_err(range_err)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        vseq_lane #(.WORD_W(WORD_W)) u_lane (
            .op(cur_op),
            .en(lane_en[i]),
            .a(rd_a_data[i*WORD_W +: WORD_W]),
            .b(rd_b_data[i*WORD_W +: WORD_W]),
            .old(rd_d_data[i*WORD_W +: WORD_W]),
            .res(wr_data[i*WORD_W +: WORD_W])
        );
    end
endmodule

// File: tb/tb_vseq_top.sv
module tb_vseq_top;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         issue_valid = 1'b0;
    logic [1:0]   issue_op = 2'd0;
    logic [4:0]   issue_vd = '0, issue_va = '0, issue_vb = '0;
    logic         cfg_we = 1'b0, cfg_sel = 1'b0;
    logic [31:0]  cfg_wdata = '0;
    logic [4:0]   rd_a_idx, rd_b_idx, rd_d_idx, wr_idx;
    logic [127:0] rd_a_data, rd_b_data, rd_d_data, wr_data;
    logic         wr_en, busy, done, range_err, len_err;

    logic [127:0] rf [32];
    logic [127:0] exp_rf [32];
    int           cur_len = 4;
    logic [31:0]  cur_mask = '1;
    int           errors = 0;
    int           checks = 0;
    int           cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vseq_top dut (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_op(issue_op),
        .issue_vd(issue_vd), .issue_va(issue_va), .issue_vb(issue_vb),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data), .rd_b_idx(rd_b_idx),
        .rd_b_data(rd_b_data), .rd_d_idx(rd_d_idx), .rd_d_data(rd_d_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .busy(busy),
        .done(done), .range_err(range_err), .len_err(len_err)
    );

    function automatic logic [127:0] init_val(input int s);
        logic [127:0] v;
        for (int l = 0; l < 4; l++) v[32*l +: 32] = 32'h9E37_79B9 * (s * 4 + l + 1) + 32'(s);
        return v;
    endfunction

    function automatic logic [31:0] lane_op(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
        case (op)
            2'd0: return a + b;
            2'd1: return a - b;
            2'd2: return a * b;
            default: return a;
        endcase
    endfunction

    assign rd_a_data = rf[rd_a_idx];
    assign rd_b_data = rf[rd_b_idx];
    assign rd_d_data = rf[rd_d_idx];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < 32; s++) rf[s] <= init_val(s);
        end else if (wr_en) begin
            rf[wr_idx] <= wr_data;
        end
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run hung, actual=%0d cycles expected<100000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic compare_rf(input string req);
        int bad = -1;
        for (int s = 31; s >= 0; s--) if (rf[s] !== exp_rf[s]) bad = s;
        if (bad < 0) chk(1'b1, req, '0, '0);
        else chk(1'b0, $sformatf("%s slice %0d", req, bad), rf[bad], exp_rf[bad]);
    endtask

    task automatic cfg_write(input bit sel, input logic [31:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic golden(input logic [1:0] op, input int vd, input int va, input int vb);
        int n = cur_len / 4;
        for (int k = 0; k < n; k++)
            for (int i = 0; i < 4; i++)
                if (cur_mask[k*4+i])
                    exp_rf[vd*n+k][32*i +: 32] = lane_op(op, exp_rf[va*n+k][32*i +: 32],
                                                        exp_rf[vb*n+k][32*i +: 32]);
    endtask

    task automatic run_op(input logic [1:0] op, input int vd, input int va, input int vb, input string req);
        int cnt = 0, dn = 0;
        bit done_late = 1'b0;
        golden(op, vd, va, vb);
        @(negedge clk);
        issue_valid = 1'b1; issue_op = op;
        issue_vd = 5'(vd); issue_va = 5'(va); issue_vb = 5'(vb);
        @(negedge clk);
        issue_valid = 1'b0;
        while (busy && cnt < 64) begin
            if (done) begin
                dn++;
                if (cnt != cur_len/4 - 1) done_late = 1'b1;
            end
            cnt++;
            @(negedge clk);
        end
        chk(cnt == cur_len/4, {req, " R8 beat count"}, 128'(cnt), 128'(cur_len/4));
        chk(dn == 1 && !done_late, {req, " R8 done on last beat"}, 128'(dn), 128'(1));
        compare_rf(req);
    endtask

    task automatic try_refused(input int vd, input int va, input int vb);
        @(negedge clk);
        issue_valid = 1'b1; issue_op = 2'd0;
        issue_vd = 5'(vd); issue_va = 5'(va); issue_vb = 5'(vb);
        @(negedge clk);
        issue_valid = 1'b0;
        chk(range_err && !busy && !wr_en, "R9 refusal pulse", {125'd0, range_err, busy, wr_en}, 128'b100);
        @(negedge clk);
        chk(!range_err && !busy, "R9 pulse one cycle", {126'd0, range_err, busy}, 128'b0);
        compare_rf("R9 no write");
    endtask

    task automatic t_reset();
        chk(!busy && !done && !wr_en && !range_err && !len_err, "R1 reset outputs",
            {123'd0, busy, done, wr_en, range_err, len_err}, 128'd0);
    endtask

    task automatic t_default_len();
        run_op(2'd0, 3, 1, 2, "R1 default one beat");
    endtask

    task automatic t_len16();
        cfg_write(1'b0, 32'd16); cur_len = 16;
        run_op(2'd0, 2, 0, 1, "R2 R5 len16 add");
    endtask

    task automatic t_bad_len();
        cfg_write(1'b0, 32'd18);
        chk(len_err === 1'b1, "R3 len_err set", 128'(len_err), 128'd1);
        cfg_write(1'b0, 32'd36);
        cfg_write(1'b0, 32'd0);
        cfg_write(1'b1, 32'hFFFF_FFFF);
        chk(len_err === 1'b1, "R3 len_err sticky", 128'(len_err), 128'd1);
        run_op(2'd1, 1, 2, 0, "R3 length kept");
    endtask

    task automatic t_mask();
        cfg_write(1'b0, 32'd8); cur_len = 8;
        cfg_write(1'b1, 32'hA5A5_F00F); cur_mask = 32'hA5A5_F00F;
        run_op(2'd2, 1, 2, 3, "R7 R6 masked mul");
    endtask

    task automatic t_len32();
        cfg_write(1'b1, 32'hFFFF_FFFF); cur_mask = '1;
        cfg_write(1'b0, 32'd32); cur_len = 32;
        run_op(2'd1, 1, 2, 3, "R6 R2 len32 sub");
        run_op(2'd3, 0, 3, 1, "R6 copy");
        run_op(2'd0, 2, 2, 2, "R5 in-place");
    endtask

    task automatic t_range();
        try_refused(4, 0, 0);
        try_refused(0, 0, 5);
        cfg_write(1'b0, 32'd8); cur_len = 8;
        try_refused(1, 16, 0);
        run_op(2'd0, 15, 0, 14, "R9 last legal register len8");
        cfg_write(1'b0, 32'd4); cur_len = 4;
        run_op(2'd0, 31, 30, 31, "R5 top slice len4");
    endtask

    task automatic t_busy_ignore();
        int cnt = 0;
        cfg_write(1'b0, 32'd16); cur_len = 16;
        golden(2'd0, 3, 0, 1);
        @(negedge clk);
        issue_valid = 1'b1; issue_op = 2'd0; issue_vd = 5'd3; issue_va = 5'd0; issue_vb = 5'd1;
        @(negedge clk);
        issue_op = 2'd2; issue_vd = 5'd0; issue_va = 5'd2; issue_vb = 5'd2;
        cfg_we = 1'b1; cfg_sel = 1'b1; cfg_wdata = 32'h0;
        while (busy && cnt < 64) begin
            cnt++;
            @(negedge clk);
            if (cnt == 1) begin cfg_sel = 1'b0; cfg_wdata = 32'd8; end
            if (cnt == 2) begin issue_valid = 1'b0; cfg_we = 1'b0; end
        end
        issue_valid = 1'b0; cfg_we = 1'b0;
        chk(cnt == 4, "R10 running instr keeps length", 128'(cnt), 128'd4);
        compare_rf("R4 R10 busy issue ignored");
        cur_mask = '0; cur_len = 8;
        run_op(2'd0, 2, 0, 1, "R10 new mask and length applied");
    endtask

    initial begin
        for (int s = 0; s < 32; s++) exp_rf[s] = init_val(s);
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_default_len();
        t_len16();
        t_bad_len();
        t_mask();
        t_len32();
        t_range();
        t_busy_ignore();
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule